// File: doc/BRIEF.md
# Per-Core Dead-Block Trace Predictor

This block guesses, for a shared last-level cache, which resident blocks have already received their final reference and will only sit idle until they are evicted. Every resident block keeps a short signature that is built up from the program counters of the instructions that touch it. The signature records which core made the most recent access. A small history table learns which signature and core pairs were still current when a block was evicted. When a later access leaves a block with a signature and core pair that the table knows, the block is flagged dead. A prefetcher can then replace that block early instead of waiting for normal replacement.

The cache controller reports each lookup on the access stream: core, PC, set, way and hit or miss. It reports each victim on the eviction stream. Both streams use valid/ready. Both ready outputs are held high at all times, so the block never applies back-pressure and every cycle with valid high is a transfer. The verdict for an access appears on the result outputs exactly one cycle later. The result pins have no ready input, so the consumer must take the verdict in that cycle. An access and an eviction in the same cycle must name different blocks. Cache data, prefetch address generation and coherence are handled elsewhere.

Top module: `dead_block_predictor`

## Requirements
- R1: `acc_ready` and `evict_ready` are always 1. Every cycle with `acc_valid` high gives exactly one result on the next cycle: `dead_valid` high, with `dead_set`/`dead_way` echoing that access. `dead_valid` is low in a cycle that follows no access.
- R2: A miss, or a hit on a block that is not resident, restarts the block's 15-bit signature as the PC hash: PC bit i is XORed into signature bit (i mod 15).
- R3: A hit on a resident block sets the signature to its old value rotated left by one bit, XORed with the PC hash. The order of the PCs therefore matters.
- R4: A history entry's tag is the core ID concatenated with signature bits [14:6]. An access from a different core never matches an entry trained by another core.
- R5: An access is predicted dead when the entry at index signature[5:0] (the signature after this access) is valid, its tag matches, and its 2-bit counter is at least 2.
- R6: Evicting a resident block trains the entry for its final signature and core. On a tag match the counter increments and saturates at 3. Otherwise the entry is overwritten with the new tag and a counter of 1. The evicted block stops being resident.
- R7: A hit on a block whose previous access was predicted dead decrements the counter of the entry that its previous signature and core still match, stopping at 0.
- R8: When an eviction trains the same entry that the decrement of R7 targets in the same cycle, only the training takes effect.
- R9: A lookup in the same cycle as an eviction training of the same entry sees the entry as it is after that training.
- R10: After reset the table holds no entries, no block is resident, and `dead_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access report valid |
| acc_ready | output | 1 | Always 1 |
| acc_core | input | CORE_W | Requesting core |
| acc_pc | input | PC_W | PC of the access |
| acc_set | input | log2(NUM_SETS) | Set of the block |
| acc_way | input | log2(NUM_WAYS) | Way of the block |
| acc_hit | input | 1 | 1 = hit, 0 = miss fill |
| evict_valid | input | 1 | Eviction report valid |
| evict_ready | output | 1 | Always 1 |
| evict_set | input | log2(NUM_SETS) | Set of the victim |
| evict_way | input | log2(NUM_WAYS) | Way of the victim |
| dead_valid | output | 1 | Verdict valid |
| dead_pred | output | 1 | 1 = block predicted dead |
| dead_set | output | log2(NUM_SETS) | Set of the judged block |
| dead_way | output | log2(NUM_WAYS) | Way of the judged block |

## Verification
A wrong signature, counter or tag inside the block shows at the ports only through `dead_pred`. It appears on the cycle after the first access whose lookup reaches the corrupted entry or block, which may be many accesses after the fault. The bench therefore builds each history entry through known sequences of fills, hits and evictions. It then probes the entry with a fresh block, so that a wrong count, a missed saturation, a wrong collision winner or a missing core tag changes a verdict one cycle after the probing hit.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  localparam int CTR_W       = 2;
  localparam logic [CTR_W-1:0] CTR_MAX     = 2'd3;
  localparam logic [CTR_W-1:0] CTR_FRESH   = 2'd1;
  localparam logic [CTR_W-1:0] CTR_DEADMIN = 2'd2;
endpackage

// File: rtl/dbp_block_state.sv
module dbp_block_state #(
  parameter int BLK_W  = 6,
  parameter int SIG_W  = 15,
  parameter int CORE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  rd_blk,
  output logic [SIG_W-1:0]  rd_sig,
  output logic [CORE_W-1:0] rd_core,
  output logic              rd_res,
  output logic              rd_pdead,
  input  logic [BLK_W-1:0]  ev_blk,
  output logic [SIG_W-1:0]  ev_sig,
  output logic [CORE_W-1:0] ev_core,
  output logic              ev_res,
  input  logic              wr_en,
  input  logic [SIG_W-1:0]  wr_sig,
  input  logic [CORE_W-1:0] wr_core,
  input  logic              wr_pdead,
  input  logic              clr_en
);
  localparam int BLOCKS = 1 << BLK_W;

  logic [SIG_W-1:0]  sig_q   [BLOCKS];
  logic [CORE_W-1:0] core_q  [BLOCKS];
  logic [BLOCKS-1:0] res_q;
  logic [BLOCKS-1:0] pdead_q;

  assign rd_sig   = sig_q[rd_blk];
  assign rd_core  = core_q[rd_blk];
  assign rd_res   = res_q[rd_blk];
  assign rd_pdead = pdead_q[rd_blk];
  assign ev_sig   = sig_q[ev_blk];
  assign ev_core  = core_q[ev_blk];
  assign ev_res   = res_q[ev_blk];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      sig_q[rd_blk]  <= wr_sig;
      core_q[rd_blk] <= wr_core;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q   <= '0;
      pdead_q <= '0;
    end else begin
      if (clr_en) begin
        res_q[ev_blk]   <= 1'b0;
        pdead_q[ev_blk] <= 1'b0;
      end
      if (wr_en) begin
        res_q[rd_blk]   <= 1'b1;
        pdead_q[rd_blk] <= wr_pdead;
      end
    end
  end

  p_evict_retires_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !res_q[$past(ev_blk)]);
  p_access_makes_resident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> res_q[$past(rd_blk)]);
endmodule

// File: rtl/dbp_history.sv
module dbp_history
  import dbp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int TAG_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_dead,
  input  logic             tr_en,
  input  logic [IDX_W-1:0] tr_idx,
  input  logic [TAG_W-1:0] tr_tag,
  input  logic             fb_en,
  input  logic [IDX_W-1:0] fb_idx,
  input  logic [TAG_W-1:0] fb_tag
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic             tr_hit, fb_hit, fb_apply, lk_fwd;
  logic [CTR_W-1:0] tr_ctr_nxt, fb_ctr_nxt;
  logic             lk_vld;
  logic [TAG_W-1:0] lk_tag_q;
  logic [CTR_W-1:0] lk_ctr;

  always_comb begin
    tr_hit     = vld_q[tr_idx] && (tag_q[tr_idx] == tr_tag);
    tr_ctr_nxt = !tr_hit ? CTR_FRESH :
                 (ctr_q[tr_idx] == CTR_MAX) ? CTR_MAX : ctr_q[tr_idx] + 2'd1;
    fb_hit     = vld_q[fb_idx] && (tag_q[fb_idx] == fb_tag);
    fb_ctr_nxt = (ctr_q[fb_idx] == '0) ? '0 : ctr_q[fb_idx] - 2'd1;
    fb_apply   = fb_en && fb_hit && !(tr_en && (tr_idx == fb_idx));
    lk_fwd     = tr_en && (tr_idx == lk_idx);
    lk_vld     = lk_fwd ? 1'b1       : vld_q[lk_idx];
    lk_tag_q   = lk_fwd ? tr_tag     : tag_q[lk_idx];
    lk_ctr     = lk_fwd ? tr_ctr_nxt : ctr_q[lk_idx];
    lk_dead    = lk_vld && (lk_tag_q == lk_tag) && (lk_ctr >= CTR_DEADMIN);
  end

  always_ff @(posedge clk) begin
    if (fb_apply) ctr_q[fb_idx] <= fb_ctr_nxt;
    if (tr_en) begin
      ctr_q[tr_idx] <= tr_ctr_nxt;
      tag_q[tr_idx] <= tr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     vld_q <= '0;
    else if (tr_en) vld_q[tr_idx] <= 1'b1;
  end

  p_train_saturates_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && tr_hit && ctr_q[tr_idx] == CTR_MAX) |=> ctr_q[$past(tr_idx)] == CTR_MAX);
  p_train_replaces_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && !tr_hit) |=> (ctr_q[$past(tr_idx)] == CTR_FRESH) && vld_q[$past(tr_idx)]);
  p_feedback_decrements_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_en && fb_hit && !tr_en && ctr_q[fb_idx] != '0)
      |=> ctr_q[$past(fb_idx)] == $past(ctr_q[fb_idx]) - 2'd1);
  p_train_beats_feedback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_en && fb_en && tr_hit && tr_idx == fb_idx)
      |=> ctr_q[$past(tr_idx)] >= $past(ctr_q[tr_idx]));
endmodule

// File: rtl/dead_block_predictor.sv
module dead_block_predictor #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CORE_W   = 2,
  parameter int PC_W     = 32,
  parameter int SIG_W    = 15,
  parameter int HT_IDX_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  output logic                        acc_ready,
  input  logic [CORE_W-1:0]           acc_core,
  input  logic [PC_W-1:0]             acc_pc,
  input  logic [$clog2(NUM_SETS)-1:0] acc_set,
  input  logic [$clog2(NUM_WAYS)-1:0] acc_way,
  input  logic                        acc_hit,
  input  logic                        evict_valid,
  output logic                        evict_ready,
  input  logic [$clog2(NUM_SETS)-1:0] evict_set,
  input  logic [$clog2(NUM_WAYS)-1:0] evict_way,
  output logic                        dead_valid,
  output logic                        dead_pred,
  output logic [$clog2(NUM_SETS)-1:0] dead_set,
  output logic [$clog2(NUM_WAYS)-1:0] dead_way
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int BLK_W = SET_W + WAY_W;
  localparam int TAG_W = CORE_W + SIG_W - HT_IDX_W;

  function automatic logic [SIG_W-1:0] pc_hash(input logic [PC_W-1:0] pc);
    logic [SIG_W-1:0] h;
    h = '0;
    for (int i = 0; i < PC_W; i++) h[i % SIG_W] = h[i % SIG_W] ^ pc[i];
    return h;
  endfunction

  logic [BLK_W-1:0]  acc_blk, ev_blk;
  logic [SIG_W-1:0]  old_sig, ev_sig, new_sig;
  logic [CORE_W-1:0] old_core, ev_core;
  logic              old_res, old_pdead, ev_res, continuing;
  logic              lk_dead, fb_en, tr_en;

  assign acc_ready   = 1'b1;
  assign evict_ready = 1'b1;
  assign acc_blk     = {acc_set, acc_way};
  assign ev_blk      = {evict_set, evict_way};

  dbp_block_state #(.BLK_W(BLK_W), .SIG_W(SIG_W), .CORE_W(CORE_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(acc_blk), .rd_sig(old_sig), .rd_core(old_core), .rd_res(old_res),
    .rd_pdead(old_pdead),
    .ev_blk(ev_blk), .ev_sig(ev_sig), .ev_core(ev_core), .ev_res(ev_res),
    .wr_en(acc_valid), .wr_sig(new_sig), .wr_core(acc_core), .wr_pdead(lk_dead),
    .clr_en(evict_valid)
  );

  always_comb begin
    continuing = acc_hit && old_res;
    new_sig    = continuing ? ({old_sig[SIG_W-2:0], old_sig[SIG_W-1]} ^ pc_hash(acc_pc))
                            : pc_hash(acc_pc);
    fb_en      = acc_valid && continuing && old_pdead;
    tr_en      = evict_valid && ev_res;
  end

  dbp_history #(.IDX_W(HT_IDX_W), .TAG_W(TAG_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(new_sig[HT_IDX_W-1:0]), .lk_tag({acc_core, new_sig[SIG_W-1:HT_IDX_W]}),
    .lk_dead(lk_dead),
    .tr_en(tr_en), .tr_idx(ev_sig[HT_IDX_W-1:0]), .tr_tag({ev_core, ev_sig[SIG_W-1:HT_IDX_W]}),
    .fb_en(fb_en), .fb_idx(old_sig[HT_IDX_W-1:0]), .fb_tag({old_core, old_sig[SIG_W-1:HT_IDX_W]})
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dead_valid <= 1'b0;
      dead_pred  <= 1'b0;
      dead_set   <= '0;
      dead_way   <= '0;
    end else begin
      dead_valid <= acc_valid;
      dead_pred  <= acc_valid && lk_dead;
      if (acc_valid) begin
        dead_set <= acc_set;
        dead_way <= acc_way;
      end
    end
  end

  p_result_next_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> dead_valid && dead_set == $past(acc_set) && dead_way == $past(acc_way));
  p_no_spurious_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !dead_valid && !dead_pred);
  p_distinct_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && evict_valid && acc_blk == ev_blk));
endmodule

// File: tb/dead_block_predictor_test.sv
module dead_block_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_hit, evict_valid;
  logic        acc_ready, evict_ready;
  logic [1:0]  acc_core;
  logic [31:0] acc_pc;
  logic [3:0]  acc_set, evict_set, dead_set;
  logic [1:0]  acc_way, evict_way, dead_way;
  logic        dead_valid, dead_pred;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] nb = '0;

  always #2 clk = ~clk;

  dead_block_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_core(acc_core), .acc_pc(acc_pc),
    .acc_set(acc_set), .acc_way(acc_way), .acc_hit(acc_hit),
    .evict_valid(evict_valid), .evict_ready(evict_ready),
    .evict_set(evict_set), .evict_way(evict_way),
    .dead_valid(dead_valid), .dead_pred(dead_pred), .dead_set(dead_set), .dead_way(dead_way)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_dead(input string req, input bit act, input bit exp);
    check(act == exp, req, int'(act), int'(exp));
  endtask

  function automatic logic [5:0] fresh();
    fresh = nb;
    nb = nb + 6'd1;
  endfunction

  // Called at a falling edge; returns at the next falling edge with the verdict.
  task automatic drive(input bit av, input logic [1:0] core, input logic [31:0] pc,
                       input logic [5:0] blk, input bit hit, input bit ev,
                       input logic [5:0] eblk, output bit dp, output bit dv,
                       output logic [5:0] oblk);
    acc_valid = av; acc_core = core; acc_pc = pc;
    acc_set = blk[5:2]; acc_way = blk[1:0]; acc_hit = hit;
    evict_valid = ev; evict_set = eblk[5:2]; evict_way = eblk[1:0];
    @(negedge clk);
    dp = dead_pred; dv = dead_valid; oblk = {dead_set, dead_way};
    acc_valid = 1'b0; evict_valid = 1'b0;
  endtask

  task automatic access(input logic [1:0] core, input logic [31:0] pc,
                        input logic [5:0] blk, input bit hit, output bit dp);
    bit dv; logic [5:0] ob;
    drive(1'b1, core, pc, blk, hit, 1'b0, 6'd0, dp, dv, ob);
  endtask

  task automatic evict(input logic [5:0] blk);
    bit dp, dv; logic [5:0] ob;
    drive(1'b0, 2'd0, 32'd0, 6'd0, 1'b0, 1'b1, blk, dp, dv, ob);
  endtask

  task automatic trace(input logic [1:0] core, input logic [31:0] p1, input logic [31:0] p2,
                       input logic [5:0] blk, output bit dp);
    bit d0;
    access(core, p1, blk, 1'b0, d0);
    access(core, p2, blk, 1'b1, dp);
  endtask

  task automatic train(input logic [1:0] core, input logic [31:0] p1, input logic [31:0] p2);
    bit d; logic [5:0] b;
    b = fresh();
    trace(core, p1, p2, b, d);
    evict(b);
  endtask

  task automatic t_reset;
    check(dead_valid == 1'b0, "R10 dead_valid after reset", int'(dead_valid), 0);
    check(acc_ready && evict_ready, "R1 ready high", int'(acc_ready), 1);
  endtask

  // Trace T1: fill 0x100, hit 0x004 -> signature 0x0204, index 4.
  task automatic t_train_forward;
    bit d, dv; logic [5:0] a, b, c, ob;
    train(2'd0, 32'h100, 32'h4);
    b = fresh();
    trace(2'd0, 32'h100, 32'h4, b, d);
    c = fresh();
    access(2'd0, 32'h100, c, 1'b0, d);
    chk_dead("R5 fill signature not in table", d, 1'b0);
    drive(1'b1, 2'd0, 32'h4, c, 1'b1, 1'b1, b, d, dv, ob);
    chk_dead("R9 lookup sees same-cycle training", d, 1'b1);
    check(dv && ob == c, "R1 verdict echoes block", int'(ob), int'(c));
    a = fresh();
    trace(2'd1, 32'h100, 32'h4, a, d);
    chk_dead("R4 other core does not match", d, 1'b0);
    a = fresh();
    trace(2'd0, 32'h8101, 32'h4, a, d);
    chk_dead("R2 folded fill PC hashes alike", d, 1'b1);
    a = fresh();
    trace(2'd0, 32'h4, 32'h100, a, d);
    chk_dead("R3 swapped PC order differs", d, 1'b0);
    a = fresh();
    trace(2'd0, 32'h100, 32'h8005, a, d);
    chk_dead("R3 folded hit PC hashes alike", d, 1'b1);
    // Block c was predicted dead: hitting it again lowers the T1 counter to 1.
    access(2'd0, 32'h11, c, 1'b1, d);
    chk_dead("R7 extended signature unknown", d, 1'b0);
    a = fresh();
    trace(2'd0, 32'h100, 32'h4, a, d);
    chk_dead("R7 counter decremented below threshold", d, 1'b0);
  endtask

  task automatic t_idle;
    @(negedge clk);
    check(dead_valid == 1'b0, "R1 no verdict without access", int'(dead_valid), 0);
  endtask

  // Trace T2: signature 0x0408, index 8; four trainings saturate at 3.
  task automatic t_saturate;
    bit d; logic [5:0] a;
    for (int k = 0; k < 4; k++) train(2'd0, 32'h200, 32'h8);
    a = fresh();
    trace(2'd0, 32'h200, 32'h8, a, d);
    chk_dead("R6 saturated counter predicts dead", d, 1'b1);
    access(2'd0, 32'h11, a, 1'b1, d);
    a = fresh();
    trace(2'd0, 32'h200, 32'h8, a, d);
    chk_dead("R6 saturated at 3, one decrement leaves 2", d, 1'b1);
  endtask

  // Trace T3: signature 0x0810, index 16.
  task automatic t_conflict;
    bit d, dv; logic [5:0] d3, d4, a, ob;
    train(2'd0, 32'h400, 32'h10);
    train(2'd0, 32'h400, 32'h10);
    d3 = fresh();
    trace(2'd0, 32'h400, 32'h10, d3, d);
    chk_dead("R5 counter 2 predicts dead", d, 1'b1);
    d4 = fresh();
    trace(2'd0, 32'h400, 32'h10, d4, d);
    drive(1'b1, 2'd0, 32'h11, d3, 1'b1, 1'b1, d4, d, dv, ob);
    a = fresh();
    trace(2'd0, 32'h400, 32'h10, a, d);
    chk_dead("R8 training kept, decrement dropped", d, 1'b1);
    access(2'd0, 32'h11, a, 1'b1, d);
    a = fresh();
    trace(2'd0, 32'h400, 32'h10, a, d);
    chk_dead("R8 counter reached 3 not 2", d, 1'b1);
  endtask

  // Trace T4: signature 0x1020, index 32; core 1 eviction takes the entry.
  task automatic t_replace;
    bit d; logic [5:0] a;
    train(2'd0, 32'h800, 32'h20);
    train(2'd0, 32'h800, 32'h20);
    train(2'd1, 32'h800, 32'h20);
    a = fresh();
    trace(2'd0, 32'h800, 32'h20, a, d);
    chk_dead("R6 mismatched tag replaced entry", d, 1'b0);
    a = fresh();
    trace(2'd1, 32'h800, 32'h20, a, d);
    chk_dead("R6 replaced entry starts at 1", d, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; acc_valid = 1'b0; evict_valid = 1'b0; acc_hit = 1'b0;
    acc_core = '0; acc_pc = '0; acc_set = '0; acc_way = '0;
    evict_set = '0; evict_way = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_train_forward();
    t_idle();
    t_saturate();
    t_conflict();
    t_replace();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule